// File: doc/BRIEF.md
# Registered Command Bus with Even-Parity Check

This block is the single pipeline stage that sits between a memory controller and a rank of DRAM devices on the command path. On each rising clock edge it captures the full command word: address, bank, command and control bits. It drives that word toward the DRAM side until the next edge, so the bus sees exactly one added cycle of latency. The isolation stage lowers the electrical load that the controller has to drive.

The controller may send one extra bit with every word, chosen so that the word plus that bit holds an even number of ones. The block latches the bit together with the word and checks it on the registered copy. When the check fails, the block pulls an active-low error output. That output stays low for a minimum number of cycles, so a slow monitor can still catch it.

Systems that do not use parity tie the enable strap low. The parity input is then ignored and the error output stays high. The command path works the same way in both cases. Because the block is a fixed-latency register with no stall, it has no valid/ready handshake. Every cycle carries a word, and the idle word stands for "no operation".

Top module: `cmdreg_top`

## Requirements
- R1: The value on `cmd_in` just before a rising edge appears on `cmd_out` just after that edge and holds until the next edge (one cycle of latency, no stall).
- R2: A cycle with `rst_n` low at a rising edge sets `cmd_out` to the idle word (default all ones, every select deasserted) and sets `err_n` high after that edge.
- R3: A word is faulty when the XOR of its W bits and the `par_in` bit sampled at the same edge is 1 (even parity over word plus parity bit).
- R4: With `par_en` high, a faulty word registered at edge k drives `err_n` low just after edge k+1, one cycle after the word reaches `cmd_out`. A correct word never lowers `err_n`.
- R5: Once lowered, `err_n` stays low for HOLD cycles (default 2) and then returns high, unless another fault arrives first.
- R6: A further faulty word detected while `err_n` is low restarts the HOLD count from that detection.
- R7: With `par_en` low, `par_in` has no effect. `err_n` is high after every edge, and `cmd_out` still follows R1.
- R8: Taking `par_en` low during an error hold clears the hold at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_en | input | 1 | Strap: high when the controller supplies parity |
| cmd_in | input | W (28) | Command, control, bank and address from the controller |
| par_in | input | 1 | Even-parity bit for `cmd_in` |
| cmd_out | output | W (28) | Registered word toward the DRAM devices |
| err_n | output | 1 | Active-low parity error, held HOLD cycles |

## Verification
A corrupted capture register shows up on `cmd_out` right after the next edge, as a word that differs from the one sent. A fault in the parity latch or its check shows up one edge later, either as a false low on `err_n` after clean traffic or as `err_n` staying high after a deliberately bad word. A fault in the hold counter shows up between two and four edges after an error: the pulse is too short or too long, it does not restart on a second fault, or it does not clear when the strap drops. Reset damage appears after the first edge, as a non-idle word or a low error output.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  // default geometry of the command word: 14 addr, 3 bank, 3 cmd, 8 control
  localparam int unsigned ADDR_BITS = 14;
  localparam int unsigned BANK_BITS = 3;
  localparam int unsigned CMD_BITS  = 3;
  localparam int unsigned CTL_BITS  = 8;
  localparam int unsigned WORD_BITS = ADDR_BITS + BANK_BITS + CMD_BITS + CTL_BITS;
  localparam int unsigned ERR_HOLD  = 2;

  typedef enum logic [1:0] {
    ERR_IDLE = 2'b00,
    ERR_HOLD_ST = 2'b01
  } err_state_e;
endpackage

// File: rtl/cmdreg_stage.sv
module cmdreg_stage #(
  parameter int unsigned W = cmdreg_pkg::WORD_BITS,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         pd,
  output logic [W-1:0] q,
  output logic         pq
);
  localparam logic IDLE_PAR = ^IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q  <= IDLE;
      pq <= IDLE_PAR;
    end else begin
      q  <= d;
      pq <= pd;
    end
  end

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (q == $past(d))); // R1
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (q == IDLE)); // R2
endmodule

// File: rtl/cmdreg_parity.sv
module cmdreg_parity #(
  parameter int unsigned W = cmdreg_pkg::WORD_BITS
) (
  input  logic [W-1:0] word,
  input  logic         pbit,
  input  logic         en,
  output logic         bad
);
  logic [W:0] acc;

  assign acc[0] = pbit;
  for (genvar i = 0; i < W; i++) begin : g_fold
    assign acc[i+1] = acc[i] ^ word[i];
  end

  assign bad = en & acc[W];

  always_comb begin
    if (!en) AST_DISABLED_NO_FAULT: assert (!bad); // R7
  end
endmodule

// File: rtl/cmdreg_errhold.sv
module cmdreg_errhold #(
  parameter int unsigned HOLD = cmdreg_pkg::ERR_HOLD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bad,
  output logic err_n
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (bad)        cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign err_n = (cnt == '0);

  AST_RESET_CLEARS_ERR: assert property (@(posedge clk)
    !rst_n |=> err_n); // R2
  AST_FAULT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> !err_n); // R4
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> $past(bad)); // R4
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_n) && en) |=> !err_n); // R5
  AST_STRAP_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> err_n); // R8
endmodule

// File: rtl/cmdreg_top.sv
module cmdreg_top #(
  parameter int unsigned W = cmdreg_pkg::WORD_BITS,
  parameter int unsigned HOLD = cmdreg_pkg::ERR_HOLD,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         par_en,
  input  logic [W-1:0] cmd_in,
  input  logic         par_in,
  output logic [W-1:0] cmd_out,
  output logic         err_n
);
  logic [W-1:0] word_q;
  logic         par_q;
  logic         fault;

  cmdreg_stage #(.W(W), .IDLE(IDLE)) u_stage (
    .clk(clk), .rst_n(rst_n), .d(cmd_in), .pd(par_in), .q(word_q), .pq(par_q)
  );

  cmdreg_parity #(.W(W)) u_par (
    .word(word_q), .pbit(par_q), .en(par_en), .bad(fault)
  );

  cmdreg_errhold #(.HOLD(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(par_en), .bad(fault), .err_n(err_n)
  );

  assign cmd_out = word_q;

  AST_OUT_STABLE_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cmd_out == $past(cmd_in))); // R1
endmodule

// File: tb/sim_cmdreg_top.sv
module sim_cmdreg_top;
  localparam int W = 28;
  localparam logic [W-1:0] IDLE = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_en = 1'b1;
  logic [W-1:0] cmd_in = IDLE;
  logic par_in = 1'b0;
  logic [W-1:0] cmd_out;
  logic err_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmdreg_top u0 (
    .clk(clk), .rst_n(rst_n), .par_en(par_en), .cmd_in(cmd_in),
    .par_in(par_in), .cmd_out(cmd_out), .err_n(err_n)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive a word before the next edge; bad=1 makes its parity odd (R3)
  task automatic put(logic [W-1:0] w, bit bad);
    @(negedge clk);
    cmd_in = w;
    par_in = (^w) ^ bad;
  endtask

  task automatic edge_after();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; cmd_in = 28'h0123456; par_in = 1'b1;
    edge_after();
    chk("R2 cmd_out idle", cmd_out, IDLE);
    chk("R2 err_n high", W'(err_n), W'(1));
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_pass();
    logic [W-1:0] pats [4] = '{28'h0000000, 28'hAAAAAAA, 28'h5555555, 28'h8C3F012};
    foreach (pats[i]) begin
      put(pats[i], 1'b0);
      edge_after();
      chk("R1 pass-through", cmd_out, pats[i]);
      chk("R4 clean word no error", W'(err_n), W'(1));
    end
    put(IDLE, 1'b0);
    edge_after();
    chk("R4 clean after run", W'(err_n), W'(1));
  endtask

  task automatic t_bad();
    put(28'h0F0F0F1, 1'b1);
    edge_after();
    chk("R1 bad word still forwarded", cmd_out, 28'h0F0F0F1);
    chk("R4 err not yet", W'(err_n), W'(1));
    put(IDLE, 1'b0);
    edge_after();
    chk("R3 R4 err low one edge later", W'(err_n), W'(0));
    edge_after();
    chk("R5 hold second cycle", W'(err_n), W'(0));
    edge_after();
    chk("R5 released after hold", W'(err_n), W'(1));
  endtask

  task automatic t_restart();
    put(28'h0000001, 1'b1);
    edge_after();
    put(28'h0000003, 1'b1);
    edge_after();
    chk("R4 first error", W'(err_n), W'(0));
    put(IDLE, 1'b0);
    edge_after();
    chk("R6 restarted", W'(err_n), W'(0));
    edge_after();
    chk("R6 restarted hold continues", W'(err_n), W'(0));
    edge_after();
    chk("R6 released", W'(err_n), W'(1));
  endtask

  task automatic t_strap_off();
    @(negedge clk); par_en = 1'b0;
    put(28'h1234567, 1'b1);
    edge_after();
    chk("R7 cmd_out follows", cmd_out, 28'h1234567);
    put(28'h7654321, 1'b1);
    edge_after();
    chk("R7 err_n high", W'(err_n), W'(1));
    edge_after();
    chk("R7 err_n still high", W'(err_n), W'(1));
    @(negedge clk); par_en = 1'b1; cmd_in = IDLE; par_in = 1'b0;
    edge_after();
  endtask

  task automatic t_strap_drop();
    put(28'h0000007, 1'b1);
    edge_after();
    put(IDLE, 1'b0);
    edge_after();
    chk("R4 error before drop", W'(err_n), W'(0));
    @(negedge clk); par_en = 1'b0;
    edge_after();
    chk("R8 hold cleared", W'(err_n), W'(1));
    @(negedge clk); par_en = 1'b1;
    edge_after();
  endtask

  task automatic t_reset_mid();
    put(28'h00000FE, 1'b1);
    edge_after();
    put(IDLE, 1'b0);
    edge_after();
    chk("R4 error before reset", W'(err_n), W'(0));
    @(negedge clk); rst_n = 1'b0; cmd_in = 28'h0ABCDEF;
    edge_after();
    chk("R2 reset idle word", cmd_out, IDLE);
    chk("R2 reset clears error", W'(err_n), W'(1));
    @(negedge clk); rst_n = 1'b1; cmd_in = IDLE; par_in = 1'b0;
  endtask

  initial begin
    t_reset();
    t_pass();
    t_bad();
    t_restart();
    t_strap_off();
    t_strap_drop();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule